// File: doc/BRIEF.md
# CAN Transmit Request Command Controller

This block turns single-cycle command strobes from a CPU register write into transmit requests for a CAN bus engine. Each write carries four command bits (queue, withdraw, self-receive and, together with queue, once-only) and a one-hot-per-buffer select mask covering the transmit buffers. The block keeps a pending flag, a once-only flag and a self-receive flag for each buffer. It offers pending buffers to the bus engine one at a time and turns the engine's done, error and lost-arbitration results into the buffer-free status, the last-outcome status and a transmit interrupt pulse.

The controller runs on three named states. `ST_IDLE` waits for a pending buffer. On the transition *pick* it latches the lowest-numbered pending buffer and moves to `ST_LAUNCH`. `ST_LAUNCH` drives the one-cycle start pulse with the buffer index and mode flags, then takes the transition *launch* to `ST_ON_BUS`. `ST_ON_BUS` waits for a result. The transition *finish* (success, or failure of a once-only frame) returns to `ST_IDLE` and reports the outcome. The transition *retry* (failure of a normal frame) returns to `ST_LAUNCH` for the same buffer.

A pending request cannot be changed or cleared by writing zero to the command bits. A withdraw-only write removes queued buffers that have not started. If the buffer it selects is already on the bus, that frame runs to its end and loses its right to retry.

Top module: `can_txcmd_ctrl`

## Requirements
- R1: After reset, `tx_buf_free` is 1, `tx_complete` is 1, and `eng_start`, `tx_irq` and `rx_irq` are 0.
- R2: A write with `cmd_queue`=1 for a free buffer makes it pending. `tx_buf_free` falls one cycle after the write. When the controller is idle, `eng_start` pulses for one cycle two cycles after the write, with `eng_buf_idx` equal to the buffer number (bit i of `cmd_buf_sel` is buffer i).
- R3: A normal frame (queue alone) that ends in `eng_err` or `eng_arb_lost` is started again for the same buffer in the cycle right after the result. No interrupt is raised for that failure.
- R4: A frame queued with `cmd_queue` and `cmd_withdraw` together is offered with `eng_single_shot`=1. On failure it is not retried: the buffer is freed, `tx_complete` becomes 0 and `tx_irq` pulses.
- R5: A frame queued with `cmd_queue` and `cmd_self_rx` together is offered with `eng_single_shot`=1 and `eng_self_rx`=1. When it succeeds, `rx_irq` pulses together with `tx_irq` if `rx_filter_match` is 1.
- R6: Queue, withdraw and self-receive together behave as the once-only case: `eng_single_shot`=1 and `eng_self_rx`=0.
- R7: A write with all command bits at 0 has no effect. A queue write aimed at an already pending buffer does not change that buffer's mode.
- R8: A withdraw-only write removes every selected buffer that is pending but not on the bus. The removed buffer is never started, and `tx_complete` becomes 0.
- R9: A withdraw aimed at the buffer on the bus does not stop the frame. A success still sets `tx_complete` to 1. A failure is not retried.
- R10: When several buffers are pending, the lowest index is started first.
- R11: `tx_buf_free` is 1 exactly when no buffer is pending or on the bus.
- R12: A finished frame sets `tx_complete` (1 on success, 0 on failure) one cycle after the result. In that same cycle `tx_irq` is high, and it lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wr | input | 1 | Command write strobe, one cycle |
| cmd_queue | input | 1 | Request transmission |
| cmd_withdraw | input | 1 | Withdraw; with queue, once-only |
| cmd_self_rx | input | 1 | Self-receive request |
| cmd_buf_sel | input | NUM_BUF | Buffer select mask, bit i = buffer i |
| eng_start | output | 1 | Start pulse to bus engine |
| eng_buf_idx | output | IDX_W | Buffer being started |
| eng_single_shot | output | 1 | No retry for this frame |
| eng_self_rx | output | 1 | Frame sent with self-reception |
| eng_done | input | 1 | Frame sent successfully |
| eng_err | input | 1 | Frame failed with bus error |
| eng_arb_lost | input | 1 | Frame lost arbitration |
| rx_filter_match | input | 1 | Acceptance filter matched own identifier |
| tx_buf_free | output | 1 | All buffers free |
| tx_complete | output | 1 | Last outcome: 1 sent, 0 failed or withdrawn |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Self-receive interrupt pulse |

## Verification
Status from a command is due one cycle after the write. The start pulse is due two cycles after the write when the controller is idle. Interrupt and outcome status are due one cycle after an engine result, and a retry start pulse is also due in that cycle. The bench drives inputs on the falling edge and checks outputs on the falling edge at these exact offsets. It sweeps every buffer, every command combination and every result kind, with expected flags worked out from the mode bits. Directed sequences cover priority, withdraw before and during a frame, and ignored writes.

// File: rtl/can_txcmd_pkg.sv
package can_txcmd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_ON_BUS = 2'd2
    } txc_state_t;

    typedef struct packed {
        logic queue;     // write asks to queue selected buffers
        logic single;    // queued frame gets no retry
        logic self_rx;   // queued frame uses self-reception
        logic withdraw;  // withdraw-only write
    } cmd_kind_t;

endpackage

// File: rtl/can_txcmd_decode.sv
module can_txcmd_decode
    import can_txcmd_pkg::*;
(
    input  logic      cmd_wr,
    input  logic      cmd_queue,
    input  logic      cmd_withdraw,
    input  logic      cmd_self_rx,
    output cmd_kind_t kind
);

    always_comb begin
        kind.queue    = cmd_wr & (cmd_queue | cmd_self_rx);
        kind.single   = cmd_withdraw | cmd_self_rx;
        kind.self_rx  = cmd_self_rx & ~cmd_withdraw;
        kind.withdraw = cmd_wr & cmd_withdraw & ~cmd_queue & ~cmd_self_rx;
    end

endmodule

// File: rtl/can_txcmd_bufq.sv
module can_txcmd_bufq
    import can_txcmd_pkg::*;
#(
    parameter int NUM_BUF = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cmd_kind_t          kind,
    input  logic [NUM_BUF-1:0] sel,
    input  logic [NUM_BUF-1:0] active_oh,
    input  logic [NUM_BUF-1:0] fin_oh,
    output logic [NUM_BUF-1:0] pending,
    output logic [NUM_BUF-1:0] single_v,
    output logic [NUM_BUF-1:0] self_v,
    output logic [NUM_BUF-1:0] withdrawn
);

    for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
        logic set_i, clr_i, promote_i;

        always_comb begin
            set_i     = kind.queue & sel[i] & ~pending[i];
            clr_i     = kind.withdraw & sel[i] & pending[i] & ~active_oh[i];
            promote_i = kind.withdraw & sel[i] & active_oh[i];
        end

        assign withdrawn[i] = clr_i;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pending[i]  <= 1'b0;
                single_v[i] <= 1'b0;
                self_v[i]   <= 1'b0;
            end else if (set_i) begin
                pending[i]  <= 1'b1;
                single_v[i] <= kind.single;
                self_v[i]   <= kind.self_rx;
            end else if (clr_i || fin_oh[i]) begin
                pending[i]  <= 1'b0;
                single_v[i] <= 1'b0;
                self_v[i]   <= 1'b0;
            end else if (promote_i) begin
                single_v[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/can_txcmd_pick.sv
module can_txcmd_pick #(
    parameter int NUM_BUF = 3,
    parameter int IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic [NUM_BUF-1:0] req,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = NUM_BUF - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/can_txcmd_fsm.sv
module can_txcmd_fsm
    import can_txcmd_pkg::*;
#(
    parameter int NUM_BUF = 3,
    parameter int IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pick_found,
    input  logic [IDX_W-1:0]   pick_idx,
    input  logic [NUM_BUF-1:0] single_v,
    input  logic [NUM_BUF-1:0] self_v,
    input  logic               withdraw_any,
    input  logic               eng_done,
    input  logic               eng_err,
    input  logic               eng_arb_lost,
    input  logic               rx_filter_match,
    output logic               eng_start,
    output logic [IDX_W-1:0]   eng_buf_idx,
    output logic               eng_single_shot,
    output logic               eng_self_rx,
    output logic [NUM_BUF-1:0] active_oh,
    output logic [NUM_BUF-1:0] fin_oh,
    output logic               tx_irq,
    output logic               rx_irq,
    output logic               tx_complete
);

    txc_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             fail, finish, finish_ok;

    assign fail = eng_err | eng_arb_lost;

    // next state and finish decision
    always_comb begin
        state_d   = state_q;
        idx_d     = idx_q;
        finish    = 1'b0;
        finish_ok = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_found) begin
                    state_d = ST_LAUNCH;
                    idx_d   = pick_idx;
                end
            end
            ST_LAUNCH: state_d = ST_ON_BUS;
            ST_ON_BUS: begin
                if (eng_done) begin
                    state_d   = ST_IDLE;
                    finish    = 1'b1;
                    finish_ok = 1'b1;
                end else if (fail) begin
                    if (single_v[idx_q]) begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                    end else begin
                        state_d = ST_LAUNCH;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // outputs
    always_comb begin
        eng_start       = (state_q == ST_LAUNCH);
        eng_buf_idx     = idx_q;
        eng_single_shot = (state_q == ST_LAUNCH) & single_v[idx_q];
        eng_self_rx     = (state_q == ST_LAUNCH) & self_v[idx_q];
        active_oh       = (state_q != ST_IDLE) ? (NUM_BUF'(1) << idx_q) : '0;
        fin_oh          = finish ? (NUM_BUF'(1) << idx_q) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_irq      <= 1'b0;
            rx_irq      <= 1'b0;
            tx_complete <= 1'b1;
        end else begin
            tx_irq <= finish;
            rx_irq <= finish_ok & self_v[idx_q] & rx_filter_match;
            if (finish)            tx_complete <= finish_ok;
            else if (withdraw_any) tx_complete <= 1'b0;
        end
    end

    // R3
    retry_same_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ON_BUS && !eng_done && fail && !single_v[idx_q])
        |=> (eng_start && !tx_irq && $stable(idx_q)));

    // R4
    no_retry_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ON_BUS && !eng_done && fail && single_v[idx_q])
        |=> (!eng_start && tx_irq && !tx_complete));

    // R9
    frame_runs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ON_BUS && !eng_done && !fail) |=> (state_q == ST_ON_BUS));

    // R12
    irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

endmodule

// File: rtl/can_txcmd_ctrl.sv
module can_txcmd_ctrl
    import can_txcmd_pkg::*;
#(
    parameter int NUM_BUF = 3,
    parameter int IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic               cmd_queue,
    input  logic               cmd_withdraw,
    input  logic               cmd_self_rx,
    input  logic [NUM_BUF-1:0] cmd_buf_sel,
    output logic               eng_start,
    output logic [IDX_W-1:0]   eng_buf_idx,
    output logic               eng_single_shot,
    output logic               eng_self_rx,
    input  logic               eng_done,
    input  logic               eng_err,
    input  logic               eng_arb_lost,
    input  logic               rx_filter_match,
    output logic               tx_buf_free,
    output logic               tx_complete,
    output logic               tx_irq,
    output logic               rx_irq
);

    cmd_kind_t          kind;
    logic [NUM_BUF-1:0] pending, single_v, self_v, withdrawn;
    logic [NUM_BUF-1:0] active_oh, fin_oh, avail;
    logic               pick_found;
    logic [IDX_W-1:0]   pick_idx;

    can_txcmd_decode u_decode (
        .cmd_wr       (cmd_wr),
        .cmd_queue    (cmd_queue),
        .cmd_withdraw (cmd_withdraw),
        .cmd_self_rx  (cmd_self_rx),
        .kind         (kind)
    );

    can_txcmd_bufq #(.NUM_BUF(NUM_BUF)) u_bufq (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .sel       (cmd_buf_sel),
        .active_oh (active_oh),
        .fin_oh    (fin_oh),
        .pending   (pending),
        .single_v  (single_v),
        .self_v    (self_v),
        .withdrawn (withdrawn)
    );

    assign avail = pending & ~withdrawn;

    can_txcmd_pick #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_pick (
        .req   (avail),
        .found (pick_found),
        .idx   (pick_idx)
    );

    can_txcmd_fsm #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .pick_found      (pick_found),
        .pick_idx        (pick_idx),
        .single_v        (single_v),
        .self_v          (self_v),
        .withdraw_any    (|withdrawn),
        .eng_done        (eng_done),
        .eng_err         (eng_err),
        .eng_arb_lost    (eng_arb_lost),
        .rx_filter_match (rx_filter_match),
        .eng_start       (eng_start),
        .eng_buf_idx     (eng_buf_idx),
        .eng_single_shot (eng_single_shot),
        .eng_self_rx     (eng_self_rx),
        .active_oh       (active_oh),
        .fin_oh          (fin_oh),
        .tx_irq          (tx_irq),
        .rx_irq          (rx_irq),
        .tx_complete     (tx_complete)
    );

    assign tx_buf_free = ~|pending;

    // R11
    start_not_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !tx_buf_free);

    // R10
    lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> ((pending & ((NUM_BUF'(1) << eng_buf_idx) - NUM_BUF'(1))) == '0));

endmodule

// File: tb/can_txcmd_ctrl_bench.sv
module can_txcmd_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 3;
    localparam int IW         = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr = 0, cmd_queue = 0, cmd_withdraw = 0, cmd_self_rx = 0;
    logic [NB-1:0] cmd_buf_sel = '0;
    logic          eng_done = 0, eng_err = 0, eng_arb_lost = 0, rx_filter_match = 0;
    logic          eng_start, eng_single_shot, eng_self_rx;
    logic [IW-1:0] eng_buf_idx;
    logic          tx_buf_free, tx_complete, tx_irq, rx_irq;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_txcmd_ctrl #(.NUM_BUF(NB)) u_can_txcmd_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cmd_wr), .cmd_queue(cmd_queue), .cmd_withdraw(cmd_withdraw),
        .cmd_self_rx(cmd_self_rx), .cmd_buf_sel(cmd_buf_sel),
        .eng_start(eng_start), .eng_buf_idx(eng_buf_idx),
        .eng_single_shot(eng_single_shot), .eng_self_rx(eng_self_rx),
        .eng_done(eng_done), .eng_err(eng_err), .eng_arb_lost(eng_arb_lost),
        .rx_filter_match(rx_filter_match),
        .tx_buf_free(tx_buf_free), .tx_complete(tx_complete),
        .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // all tasks start and end on a falling edge
    task automatic cmd(input bit q, input bit w, input bit s, input logic [NB-1:0] sel);
        cmd_wr = 1; cmd_queue = q; cmd_withdraw = w; cmd_self_rx = s; cmd_buf_sel = sel;
        step();
        cmd_wr = 0; cmd_queue = 0; cmd_withdraw = 0; cmd_self_rx = 0; cmd_buf_sel = '0;
    endtask

    // kind: 0 done, 1 error, 2 arbitration lost
    task automatic result(input int kind);
        eng_done = (kind == 0); eng_err = (kind == 1); eng_arb_lost = (kind == 2);
        step();
        eng_done = 0; eng_err = 0; eng_arb_lost = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step();
        // R1 reset values
        chk("R1 free", tx_buf_free, 1);
        chk("R1 complete", tx_complete, 1);
        chk("R1 start", eng_start, 0);
        chk("R1 irq", tx_irq, 0);
        chk("R1 rxirq", rx_irq, 0);
        rst_n = 1;
        step(); step();

        // sweep: buffer x mode x outcome
        for (int b = 0; b < NB; b++) begin
            for (int m = 0; m < 4; m++) begin
                for (int o = 0; o < 3; o++) begin
                    bit single, selfx, retry;
                    single = (m != 0);
                    selfx  = (m == 2);
                    retry  = !single && (o != 0);
                    rx_filter_match = (b != 1);
                    cmd(1'b1, m[0], m[1], NB'(1) << b);
                    chk("R11 busy", tx_buf_free, 0);
                    chk("R2 no early start", eng_start, 0);
                    step();
                    chk("R2 start", eng_start, 1);
                    chk("R2 idx", eng_buf_idx, b);
                    chk(m == 1 ? "R4 single" : (m == 3 ? "R6 single" : "R5 single"),
                        eng_single_shot, single);
                    chk(m == 3 ? "R6 self" : "R5 self", eng_self_rx, selfx);
                    step();
                    result(o);
                    if (retry) begin
                        chk("R3 retry start", eng_start, 1);
                        chk("R3 retry idx", eng_buf_idx, b);
                        chk("R3 no irq", tx_irq, 0);
                        chk("R11 still busy", tx_buf_free, 0);
                        step();
                        result(0);
                    end
                    chk("R12 irq", tx_irq, 1);
                    chk("R12 complete", tx_complete, (retry || o == 0) ? 1 : 0);
                    chk("R4 freed", tx_buf_free, 1);
                    chk("R5 rx irq", rx_irq, (selfx && (retry || o == 0) && b != 1) ? 1 : 0);
                    chk("R4 no restart", eng_start, 0);
                    step();
                    chk("R12 pulse end", tx_irq, 0);
                end
            end
        end

        // R7 all-zero write
        cmd(1'b0, 1'b0, 1'b0, '1);
        for (int k = 0; k < 3; k++) begin
            chk("R7 zero write start", eng_start, 0);
            chk("R7 zero write free", tx_buf_free, 1);
            step();
        end
        // R7 queue on pending buffer keeps once-only mode
        cmd(1'b1, 1'b1, 1'b0, 3'b010);
        cmd(1'b1, 1'b0, 1'b0, 3'b010);
        chk("R7 start", eng_start, 1);
        chk("R7 mode kept", eng_single_shot, 1);
        step();
        result(1);
        chk("R7 no retry", eng_start, 0);
        chk("R7 freed", tx_buf_free, 1);
        step();

        // R10 priority
        cmd(1'b1, 1'b0, 1'b0, 3'b101);
        step();
        chk("R10 first", eng_buf_idx, 0);
        step();
        result(0);
        chk("R10 gap", eng_start, 0);
        chk("R11 one left", tx_buf_free, 0);
        step();
        chk("R10 second start", eng_start, 1);
        chk("R10 second", eng_buf_idx, 2);
        step();
        result(0);
        chk("R11 all free", tx_buf_free, 1);
        step();

        // R8 withdraw queued, R9 withdraw active then fail
        cmd(1'b1, 1'b0, 1'b0, 3'b011);
        step();
        chk("R8 start 0", eng_buf_idx, 0);
        step();
        cmd(1'b0, 1'b1, 1'b0, 3'b011);
        chk("R8 complete cleared", tx_complete, 0);
        result(1);
        chk("R9 no retry", eng_start, 0);
        chk("R9 irq", tx_irq, 1);
        chk("R8 free", tx_buf_free, 1);
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R8 never started", eng_start, 0);
        end

        // R9 withdraw active then success
        cmd(1'b1, 1'b0, 1'b0, 3'b001);
        step();
        step();
        cmd(1'b0, 1'b1, 1'b0, 3'b001);
        chk("R9 still running", tx_buf_free, 0);
        result(0);
        chk("R9 complete", tx_complete, 1);
        chk("R9 irq ok", tx_irq, 1);
        step();

        done_flag = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule